// File: doc/BRIEF.md
# Video Processor Register Interface

This block is the processor-facing register file of a tile-and-sprite video engine. A host processor writes a control byte and a mask byte through a small port window and reads back a status byte. The stored fields drive the rendering logic as plain outputs. The block also derives a bus-activity signal from the two rendering enables.

Three status flags live here: vertical blank, sprite-0 hit and sprite overflow. Strobes from the renderer set them. A status read clears the blank flag. A line counter clears all three flags a fixed number of scanlines after blanking begins. The block raises a level interrupt while the blank flag is set and interrupts are enabled. It also keeps a 14-bit video address. The host loads that address with two byte writes, and each data-port access steps it by 1 or by 32. The renderer, memories and palette are not part of this block.

Port window (3-bit address): 0 control, 1 mask, 2 status, 6 address load, 7 data. Writes to 2 only update the open-bus latch.

Top module: `vpu_regif`

## Requirements
- R1: Control and mask are 8-bit write-only registers. Either reset (`por_n` or `rst_n` low) clears them to 0x00. A write to port 0 or port 1 appears on `ctrl_q` or `mask_q` after the next clock edge.
- R2: `irq` is a level output, high exactly while the blank flag is set and control bit 7 is 1. Setting bit 7 while the flag is already high raises `irq` in the cycle after that write.
- R3: A read or write on port 7 moves `video_addr` by 32 when control bit 2 is 1 and by 1 when it is 0. The address wraps modulo 2^14. With no port 6 or port 7 access, the address holds.
- R4: A read of port 2 returns bit 7 = blank flag, bit 6 = sprite-0 flag, bit 5 = overflow flag and bits 4:0 = bits 4:0 of the open-bus latch.
- R5: A status read clears the blank flag at that clock edge, and the byte returned holds the value from before the clear. If `vblank_start` falls in the same cycle as the read, the set wins: the read shows 0 in bit 7 and the flag is 1 afterwards.
- R6: `vblank_start`, `spr0_hit` and `spr_ovf` set their flags, which then stay set. Status reads do not clear the sprite-0 or overflow flag.
- R7: On the `LINES_TO_CLEAR`-th (default 20) `line_end` strobe after `vblank_start`, all three flags clear. That clear beats a flag strobe in the same cycle.
- R8: Power-on reset (`por_n` low) clears all three flags. The other reset (`rst_n` low) leaves them unchanged.
- R9: `bus_active` is 1 when mask bit 4 or mask bit 3 is 1, and 0 only when both are 0.
- R10: Every write to any port loads its data byte into the open-bus latch. A read of any port other than 2 returns the whole latch.
- R11: Port 6 takes two writes. The first loads address bits 13:8 from data bits 5:0, and the second loads bits 7:0. A status read returns the sequence to its first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Other reset, active low, synchronous |
| cpu_wr_en | input | 1 | Host write strobe |
| cpu_rd_en | input | 1 | Host read strobe |
| cpu_addr | input | 3 | Port select |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data, combinational |
| vblank_start | input | 1 | Renderer strobe: blanking begins |
| line_end | input | 1 | Renderer strobe: a scanline ended |
| spr0_hit | input | 1 | Renderer strobe: sprite-0 overlap |
| spr_ovf | input | 1 | Renderer strobe: sprite overflow |
| ctrl_q | output | 8 | Stored control byte |
| mask_q | output | 8 | Stored mask byte |
| bus_active | output | 1 | Rendering bus in use |
| irq | output | 1 | Interrupt request level |
| video_addr | output | 14 | Internal video address |

## Verification
The blank flag has two sources that can land on one clock edge: a status read clears it and the renderer's blank strobe sets it. The bench raises both strobes in a single cycle. It checks that the byte read shows bit 7 clear and that the flag reads as set on the next status read. The line-count clear meets a sprite-0 strobe in the same way: the bench fires the two on the final counted line and expects all three flags to read back as zero.

// File: rtl/vpu_regif_pkg.sv
package vpu_regif_pkg;
  localparam int VADDR_W = 14;
  localparam int PORT_W  = 3;

  localparam logic [PORT_W-1:0] PORT_CTRL = 3'd0;
  localparam logic [PORT_W-1:0] PORT_MASK = 3'd1;
  localparam logic [PORT_W-1:0] PORT_STAT = 3'd2;
  localparam logic [PORT_W-1:0] PORT_ADDR = 3'd6;
  localparam logic [PORT_W-1:0] PORT_DATA = 3'd7;

  localparam int CTRL_IRQ_EN_BIT = 7;
  localparam int CTRL_WIDE_BIT   = 2;
  localparam int MASK_SPR_BIT    = 4;
  localparam int MASK_BG_BIT     = 3;

  // Address step after a data-port access, wrapping at the address width.
  function automatic logic [VADDR_W-1:0] step_vaddr(logic [VADDR_W-1:0] a, logic wide);
    logic [VADDR_W-1:0] inc;
    inc = wide ? VADDR_W'(32) : VADDR_W'(1);
    return a + inc;
  endfunction

  // Status byte layout: three flags on top, low open-bus bits below.
  function automatic logic [7:0] pack_status(logic vbl, logic s0, logic ovf, logic [7:0] ob);
    return {vbl, s0, ovf, ob[4:0]};
  endfunction
endpackage

// File: rtl/vpu_cfg_regs.sv
module vpu_cfg_regs
  import vpu_regif_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        mask_q,
  output logic [7:0]        ob_q,
  output logic              bus_active
);
  logic wr_ctrl, wr_mask;
  assign wr_ctrl = wr_en && (addr == PORT_CTRL);
  assign wr_mask = wr_en && (addr == PORT_MASK);

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      ob_q   <= '0;
    end else begin
      if (wr_en)   ob_q   <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign bus_active = mask_q[MASK_SPR_BIT] | mask_q[MASK_BG_BIT];

  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr_ctrl |=> (ctrl_q == $past(wdata)));

  p_bus_follows_mask_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr_mask |=> (bus_active == ($past(wdata[MASK_SPR_BIT]) || $past(wdata[MASK_BG_BIT]))));

  p_latch_on_write_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr_en |=> (ob_q == $past(wdata)));
endmodule

// File: rtl/vpu_status_flags.sv
module vpu_status_flags #(
  parameter int LINES_TO_CLEAR = 20,
  localparam int CNT_W = $clog2(LINES_TO_CLEAR + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic vblank_start,
  input  logic line_end,
  input  logic spr0_hit,
  input  logic spr_ovf,
  input  logic stat_rd,
  output logic vbl,
  output logic s0,
  output logic ovf,
  output logic sched_clr
);
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             last_line;

  assign last_line = (cnt == CNT_W'(LINES_TO_CLEAR - 1));
  assign sched_clr = run && line_end && last_line && !vblank_start;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      run <= 1'b0;
      cnt <= '0;
      vbl <= 1'b0;
      s0  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (vblank_start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run && line_end) begin
        if (last_line) run <= 1'b0;
        else           cnt <= cnt + 1'b1;
      end

      if (sched_clr) begin
        vbl <= 1'b0;
        s0  <= 1'b0;
        ovf <= 1'b0;
      end else begin
        if (vblank_start) vbl <= 1'b1;
        else if (stat_rd) vbl <= 1'b0;
        if (spr0_hit) s0  <= 1'b1;
        if (spr_ovf)  ovf <= 1'b1;
      end
    end
  end

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
    (stat_rd && !vblank_start) |=> !vbl);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!por_n)
    vblank_start |=> vbl);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    (s0 && !sched_clr) |=> s0);

  p_sched_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
    sched_clr |=> (!vbl && !s0 && !ovf));
endmodule

// File: rtl/vpu_vaddr_ctr.sv
module vpu_vaddr_ctr
  import vpu_regif_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [PORT_W-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               wide,
  input  logic               stat_rd,
  output logic [VADDR_W-1:0] vaddr
);
  logic second;
  logic data_acc;
  logic addr_wr;

  assign data_acc = (wr_en || rd_en) && (addr == PORT_DATA);
  assign addr_wr  = wr_en && (addr == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      vaddr  <= '0;
      second <= 1'b0;
    end else begin
      if (addr_wr) begin
        if (!second) vaddr[VADDR_W-1:8] <= wdata[VADDR_W-9:0];
        else         vaddr[7:0]         <= wdata;
        second <= !second;
      end else if (data_acc) begin
        vaddr <= step_vaddr(vaddr, wide);
      end
      if (stat_rd) second <= 1'b0;
    end
  end

  p_data_step_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (data_acc && !addr_wr) |=> (vaddr != $past(vaddr)));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!data_acc && !addr_wr) |=> $stable(vaddr));

  p_low_load_r11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (addr_wr && second) |=> (vaddr[7:0] == $past(wdata)));
endmodule

// File: rtl/vpu_regif.sv
module vpu_regif
  import vpu_regif_pkg::*;
#(
  parameter int LINES_TO_CLEAR = 20
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic               cpu_rd_en,
  input  logic [PORT_W-1:0]  cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic               vblank_start,
  input  logic               line_end,
  input  logic               spr0_hit,
  input  logic               spr_ovf,
  output logic [7:0]         ctrl_q,
  output logic [7:0]         mask_q,
  output logic               bus_active,
  output logic               irq,
  output logic [VADDR_W-1:0] video_addr
);
  logic [7:0] ob_q;
  logic       vbl, s0, ovf, sched_clr;
  logic       stat_sel, stat_rd;

  assign stat_sel = (cpu_addr == PORT_STAT);
  assign stat_rd  = cpu_rd_en && stat_sel;

  vpu_cfg_regs u_cfg (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(cpu_wr_en), .addr(cpu_addr), .wdata(cpu_wdata),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .ob_q(ob_q), .bus_active(bus_active)
  );

  vpu_status_flags #(.LINES_TO_CLEAR(LINES_TO_CLEAR)) u_flags (
    .clk(clk), .por_n(por_n),
    .vblank_start(vblank_start), .line_end(line_end),
    .spr0_hit(spr0_hit), .spr_ovf(spr_ovf), .stat_rd(stat_rd),
    .vbl(vbl), .s0(s0), .ovf(ovf), .sched_clr(sched_clr)
  );

  vpu_vaddr_ctr u_vaddr (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(cpu_wr_en), .rd_en(cpu_rd_en), .addr(cpu_addr), .wdata(cpu_wdata),
    .wide(ctrl_q[CTRL_WIDE_BIT]), .stat_rd(stat_rd), .vaddr(video_addr)
  );

  assign irq       = vbl & ctrl_q[CTRL_IRQ_EN_BIT];
  assign cpu_rdata = stat_sel ? pack_status(vbl, s0, ovf, ob_q) : ob_q;

  p_irq_on_blank_r2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (vblank_start && ctrl_q[CTRL_IRQ_EN_BIT] && !(cpu_wr_en && cpu_addr == PORT_CTRL)) |=> irq);

  p_irq_drops_on_clear_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    sched_clr |=> !irq);
endmodule

// File: tb/vpu_regif_bench.sv
module vpu_regif_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 20;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0, cpu_rd_en = 1'b0;
  logic [2:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        vblank_start = 1'b0, line_end = 1'b0, spr0_hit = 1'b0, spr_ovf = 1'b0;
  logic [7:0]  ctrl_q, mask_q;
  logic        bus_active, irq;
  logic [13:0] video_addr;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpu_regif #(.LINES_TO_CLEAR(LINES)) u_vpu_regif (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .vblank_start(vblank_start), .line_end(line_end),
    .spr0_hit(spr0_hit), .spr_ovf(spr_ovf),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .bus_active(bus_active),
    .irq(irq), .video_addr(video_addr)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic strobe(logic v, logic l, logic s, logic o);
    @(negedge clk);
    vblank_start = v; line_end = l; spr0_hit = s; spr_ovf = o;
    @(negedge clk);
    vblank_start = 1'b0; line_end = 1'b0; spr0_hit = 1'b0; spr_ovf = 1'b0;
  endtask

  function automatic logic [13:0] nxt(logic [13:0] a, logic big);
    int v;
    v = int'(a) + (big ? 32 : 1);
    return 14'(v % 16384);
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R1 ctrl after reset", 16'(ctrl_q), 16'h00);
    check("R1 mask after reset", 16'(mask_q), 16'h00);
    check("R9 bus idle after reset", 16'(bus_active), 16'h0);
    check("R2 irq after reset", 16'(irq), 16'h0);
    rd(3'd2, d);
    check("R8 flags after power-on", 16'(d), 16'h00);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    wr(3'd0, 8'h25);
    check("R1 ctrl load", 16'(ctrl_q), 16'h25);
    wr(3'd1, 8'h10);
    check("R1 mask load", 16'(mask_q), 16'h10);
    check("R9 sprite enable only", 16'(bus_active), 16'h1);
    wr(3'd1, 8'h08);
    check("R9 background enable only", 16'(bus_active), 16'h1);
    wr(3'd1, 8'hE7);
    check("R9 both enables clear", 16'(bus_active), 16'h0);
    wr(3'd2, 8'h5B);
    check("R1 status write leaves ctrl", 16'(ctrl_q), 16'h25);
    rd(3'd0, d);
    check("R10 latch on non-status read", 16'(d), 16'h5B);
    rd(3'd2, d);
    check("R4 status low bits from latch", 16'(d), 16'h1B);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(3'd0, 8'h00);
    strobe(1, 0, 0, 0);
    check("R2 no irq when disabled", 16'(irq), 16'h0);
    wr(3'd0, 8'h80);
    check("R2 irq on late enable", 16'(irq), 16'h1);
    rd(3'd2, d);
    check("R4 status shows blank flag", 16'(d), 16'h80);
    check("R5 read drops irq", 16'(irq), 16'h0);
    rd(3'd2, d);
    check("R5 blank flag cleared by read", 16'(d), 16'h00);
    strobe(1, 0, 0, 0);
    check("R2 irq at blank start", 16'(irq), 16'h1);
    rd(3'd2, d);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_addr = 3'd2; vblank_start = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd_en = 1'b0; vblank_start = 1'b0;
    check("R5 same-cycle read shows old flag", 16'(d), 16'h00);
    check("R5 set wins over read clear", 16'(irq), 16'h1);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 0, 1);
    rd(3'd2, d);
    check("R6 all three flags", 16'(d), 16'hE0);
    rd(3'd2, d);
    check("R6 sprite flags survive read", 16'(d), 16'h60);
  endtask

  task automatic t_sched;
    logic [7:0] d;
    strobe(1, 0, 1, 1);
    for (int i = 0; i < LINES - 1; i++) strobe(0, 1, 0, 0);
    check("R7 flags kept before last line", 16'(irq), 16'h1);
    strobe(0, 1, 1, 0);
    check("R7 irq after scheduled clear", 16'(irq), 16'h0);
    rd(3'd2, d);
    check("R7 all flags cleared, clear beats strobe", 16'(d & 8'hE0), 16'h00);
  endtask

  task automatic t_soft_reset;
    logic [7:0] d;
    strobe(1, 0, 1, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    check("R1 ctrl cleared by soft reset", 16'(ctrl_q), 16'h00);
    check("R3 address cleared by soft reset", 16'(video_addr), 16'h0000);
    rd(3'd2, d);
    check("R8 flags kept over soft reset", 16'(d), 16'hE0);
  endtask

  task automatic t_vaddr;
    logic [7:0] d;
    logic [13:0] exp;
    wr(3'd6, 8'hFF);
    wr(3'd6, 8'hF0);
    exp = 14'h3FF0;
    check("R11 two-write address load", 16'(video_addr), 16'(exp));
    wr(3'd7, 8'h11);
    exp = nxt(exp, 1'b0);
    check("R3 step by one", 16'(video_addr), 16'(exp));
    wr(3'd0, 8'h04);
    rd(3'd7, d);
    exp = nxt(exp, 1'b1);
    check("R3 step by 32 with wrap", 16'(video_addr), 16'(exp));
    rd(3'd1, d);
    check("R3 other port leaves address", 16'(video_addr), 16'(exp));
    wr(3'd6, 8'h12);
    rd(3'd2, d);
    wr(3'd6, 8'h05);
    wr(3'd6, 8'h34);
    check("R11 status read restarts sequence", 16'(video_addr), 16'h0534);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_irq;
    t_collide;
    t_sched;
    t_soft_reset;
    t_vaddr;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule